// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block is the interrupt front end for a bank of general-purpose I/O ports. It gathers a wide pin bus into eight interrupt groups. Pin number n of any port can only reach group n mod 8. Each group has a 4-bit routing field that picks one 8-pin byte lane out of the whole bank, and the group then watches the pin of that lane whose position equals the group number.

Each group carries a 3-bit trigger code that chooses its behaviour:
- level high or level low;
- a forced-pending setting;
- rising, falling or both edges, each latched until software acknowledges it.

Every pin passes through a two-stage synchronizer before it is evaluated. A mask selects which pending groups reach the single combined interrupt line, and that line is registered.

Software reaches the block through a plain word-addressed port with a valid strobe and a write flag. Read data appears one cycle after the request. Besides the three configuration registers, the port exposes an acknowledge register that clears bits written as one, a raw status view and a masked status view.

Top module: `gpio_grp_irq`

## Requirements
- R1: Registers sit at word addresses 30 (trigger codes, group g at bits [3g+2:3g]), 31 (lane select, group g at bits [4g+3:4g]), 32 (mask, bit g), 33 (acknowledge, write only, bit g), 34 (raw pending, bit g) and 35 (masked pending, bit g). A read returns on rd_data_o one clock after the request. Unused bits read as zero, and so do unused addresses.
- R2: After reset, the trigger codes, lane selects and mask are all zero and irq_o is low. A group with code 0 (off) or code 4 (reserved) never shows a pending bit.
- R3: With code 1, a group's pending bit follows the high level of its selected pin. With code 2, it follows the low level. Neither level code latches the pending bit.
- R4: Masked status is the raw pending bits ANDed with the mask. irq_o is the OR of the masked bits, delayed by one register.
- R5: Code 5 (rising edge), code 6 (falling edge) and code 7 (either edge) set a pending bit. That bit stays set after the pin returns to its previous level.
- R6: A write to the acknowledge register clears the edge-latched pending bit of each group whose data bit is 1. Data bits of 0 leave their groups untouched. An acknowledge has no lasting effect on a level-coded or forced group.
- R7: A lane select value L routes pin bus bit 8*L+g to group g, where L = 4 × port + (pin / 8) for a 32-pin port. Pins outside that position have no effect on the group.
- R8: Code 3 holds the group pending regardless of its pin.
- R9: A pin edge applied just before clock edge 1 sets the raw pending bit at edge 3 and raises irq_o at edge 4.
- R10: Writes to the raw and masked status addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 128 | Pin bus, port p at bits [32p+31:32p] |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 6 | Word address |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid one cycle after a read request |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench sweeps every group through all eight trigger codes on a lane chosen per group. For each combination it checks the raw status, the masked status and irq_o after a low phase, a high phase, a return to low and an acknowledge.

Several wrong designs would show up in this sweep:
- A design that latched the level codes would still report pending after the pin drops.
- A design that forgot the sticky edge bit would lose a rising edge once the pin falls.
- A design that let reserved code 4 act as an edge code would raise an interrupt where none is expected.

Dedicated cases cover the rest:
- Pins one lane away, or one position away, must not disturb a group; a wrong routing multiplier would trip this.
- An acknowledge with zero bits must not clear anything.
- A masked-off pending bit must stay off irq_o.
- The exact edge on which irq_o rises is checked, so a missing or extra synchronizer stage shows up.

// File: rtl/gpio_grp_pkg.sv
`timescale 1ns/1ps
package gpio_grp_pkg;
    localparam int NGRP   = 8;
    localparam int CODE_W = 3;
    localparam int LANE_W = 4;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int CFG_W  = NGRP * CODE_W;
    localparam int SEL_W  = NGRP * LANE_W;

    typedef enum logic [CODE_W-1:0] {
        TRG_OFF   = 3'd0,
        TRG_HIGH  = 3'd1,
        TRG_LOW   = 3'd2,
        TRG_FORCE = 3'd3,
        TRG_RSV   = 3'd4,
        TRG_RISE  = 3'd5,
        TRG_FALL  = 3'd6,
        TRG_BOTH  = 3'd7
    } trig_e;

    localparam logic [ADDR_W-1:0] A_TRIG = 6'd30;
    localparam logic [ADDR_W-1:0] A_LANE = 6'd31;
    localparam logic [ADDR_W-1:0] A_MASK = 6'd32;
    localparam logic [ADDR_W-1:0] A_ACK  = 6'd33;
    localparam logic [ADDR_W-1:0] A_RAW  = 6'd34;
    localparam logic [ADDR_W-1:0] A_MSK  = 6'd35;
endpackage

// File: rtl/gpio_grp_sync.sv
`timescale 1ns/1ps
module gpio_grp_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] pv;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pins_i;
        st_d.s2 = st_q.s1;
        st_d.pv = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_o  = st_q.s2;
    assign prev_o = st_q.pv;
endmodule

// File: rtl/gpio_grp_pend.sv
`timescale 1ns/1ps
module gpio_grp_pend
    import gpio_grp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              cur_i,
    input  logic              prev_i,
    input  logic              ack_i,
    output logic              pend_o
);
    typedef struct packed {
        logic pend;
    } pend_t;

    pend_t st_d, st_q;
    logic  rise, fall, held;

    always_comb begin
        rise = cur_i & ~prev_i;
        fall = ~cur_i & prev_i;
        held = st_q.pend & ~ack_i;
        st_d = st_q;
        case (trig_e'(code_i))
            TRG_HIGH:  st_d.pend = cur_i;
            TRG_LOW:   st_d.pend = ~cur_i;
            TRG_FORCE: st_d.pend = 1'b1;
            TRG_RISE:  st_d.pend = held | rise;
            TRG_FALL:  st_d.pend = held | fall;
            TRG_BOTH:  st_d.pend = held | rise | fall;
            default:   st_d.pend = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_i) == TRG_OFF || $past(code_i) == TRG_RSV) |-> !pend_o); // R2
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_i) == TRG_HIGH) |-> (pend_o == $past(cur_i))); // R3
    AST_FORCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_i) == TRG_FORCE) |-> pend_o); // R8
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_i) == TRG_BOTH && $past(pend_o) && !$past(ack_i)) |-> pend_o); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_i) == TRG_RISE && $past(ack_i) && !($past(cur_i) && !$past(prev_i))) |-> !pend_o); // R6
endmodule

// File: rtl/gpio_grp_regs.sv
`timescale 1ns/1ps
module gpio_grp_regs
    import gpio_grp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [NGRP-1:0]   raw_i,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [SEL_W-1:0]  lane_o,
    output logic [NGRP-1:0]   mask_o,
    output logic [NGRP-1:0]   ack_o,
    output logic [DATA_W-1:0] rd_data_o
);
    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [SEL_W-1:0]  lane;
        logic [NGRP-1:0]   mask;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t             st_d, st_q;
    logic [DATA_W-1:0] rmux;

    always_comb begin
        case (req_addr_i)
            A_TRIG:  rmux = DATA_W'(st_q.cfg);
            A_LANE:  rmux = DATA_W'(st_q.lane);
            A_MASK:  rmux = DATA_W'(st_q.mask);
            A_RAW:   rmux = DATA_W'(raw_i);
            A_MSK:   rmux = DATA_W'(raw_i & st_q.mask);
            default: rmux = '0;
        endcase
    end

    always_comb begin
        st_d  = st_q;
        ack_o = '0;
        if (req_valid_i) begin
            if (req_write_i) begin
                case (req_addr_i)
                    A_TRIG:  st_d.cfg  = req_wdata_i[CFG_W-1:0];
                    A_LANE:  st_d.lane = req_wdata_i[SEL_W-1:0];
                    A_MASK:  st_d.mask = req_wdata_i[NGRP-1:0];
                    A_ACK:   ack_o     = req_wdata_i[NGRP-1:0];
                    default: ;
                endcase
            end else begin
                st_d.rdata = rmux;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o     = st_q.cfg;
    assign lane_o    = st_q.lane;
    assign mask_o    = st_q.mask;
    assign rd_data_o = st_q.rdata;

    AST_ACK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (req_valid_i && req_write_i && req_addr_i == A_ACK)); // R6
    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && (req_addr_i == A_RAW || req_addr_i == A_MSK))
        |=> ($stable(cfg_o) && $stable(lane_o) && $stable(mask_o))); // R10
endmodule

// File: rtl/gpio_grp_irq.sv
`timescale 1ns/1ps
module gpio_grp_irq
    import gpio_grp_pkg::*;
#(
    parameter int PORTS  = 4,
    parameter int PORT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PORTS*PORT_W-1:0] pins_i,
    input  logic                    req_valid_i,
    input  logic                    req_write_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic [DATA_W-1:0]       req_wdata_i,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic                    irq_o
);
    localparam int PIN_W = PORTS * PORT_W;
    localparam int LANES = PIN_W / NGRP;

    logic [PIN_W-1:0] cur_w, prev_w;
    logic [CFG_W-1:0] cfg_w;
    logic [SEL_W-1:0] lane_w;
    logic [NGRP-1:0]  mask_w, ack_w, raw_w;

    gpio_grp_sync #(.W(PIN_W)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    gpio_grp_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .raw_i       (raw_w),
        .cfg_o       (cfg_w),
        .lane_o      (lane_w),
        .mask_o      (mask_w),
        .ack_o       (ack_w),
        .rd_data_o   (rd_data_o)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [LANE_W-1:0] lane;
        logic              sel_cur, sel_prev;
        int                idx;

        assign lane = lane_w[LANE_W*g +: LANE_W];

        always_comb begin
            idx      = int'(lane) * NGRP + g;
            sel_cur  = 1'b0;
            sel_prev = 1'b0;
            if (int'(lane) < LANES) begin
                sel_cur  = cur_w[idx];
                sel_prev = prev_w[idx];
            end
        end

        gpio_grp_pend i_pend (
            .clk    (clk),
            .rst_n  (rst_n),
            .code_i (cfg_w[CODE_W*g +: CODE_W]),
            .cur_i  (sel_cur),
            .prev_i (sel_prev),
            .ack_i  (ack_w[g]),
            .pend_o (raw_w[g])
        );
    end

    typedef struct packed {
        logic irq;
    } top_t;

    top_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(raw_w & mask_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(raw_w & mask_w))); // R4
    AST_IRQ_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_w) == '0) |-> !irq_o); // R4
endmodule

// File: tb/test_gpio_grp_irq.sv
`timescale 1ns/1ps
module test_gpio_grp_irq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] pins = '0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  rd_data;
    logic         irq;
    int           n_run = 0, n_fail = 0;
    bit           done = 0;

    always #2 clk = ~clk;

    gpio_grp_irq i_gpio_grp_irq (
        .clk(clk), .rst_n(rst_n), .pins_i(pins),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        d = rd_data;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpin(int idx, bit v);
        @(negedge clk);
        pins[idx] = v;
    endtask

    // expected raw pending of one group in each phase of the sweep
    function automatic bit exp_raw(int code, int phase);
        // phase 0: pin low, 1: pin high, 2: back low, 3: after acknowledge (pin low)
        case (code)
            1: return phase == 1;
            2: return phase != 1;
            3: return 1'b1;
            5: return phase == 1 || phase == 2;
            6: return phase == 2;
            7: return phase == 1 || phase == 2;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_group(int g, int code, int phase);
        logic [31:0] d;
        bit e;
        e = exp_raw(code, phase);
        rd(6'd34, d);
        chk($sformatf("R3/R5/R6/R8 raw g%0d code%0d ph%0d", g, code, phase), d, 32'(e) << g);
        rd(6'd35, d);
        chk($sformatf("R4 masked g%0d code%0d ph%0d", g, code, phase), d, 32'(e) << g);
        chk($sformatf("R4 irq g%0d code%0d ph%0d", g, code, phase), 32'(irq), 32'(e));
    endtask

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1;
        idle(2);
        // R2 reset state
        chk("R2 irq after reset", 32'(irq), 0);
        rd(6'd30, d); chk("R2 trig reset", d, 0);
        rd(6'd31, d); chk("R2 lane reset", d, 0);
        rd(6'd32, d); chk("R2 mask reset", d, 0);
        rd(6'd34, d); chk("R2 raw reset", d, 0);

        // R1 readback and unused bits
        wr(6'd30, 32'hFFFF_FFFF); rd(6'd30, d); chk("R1 trig width", d, 32'h00FF_FFFF);
        wr(6'd32, 32'hFFFF_FFFF); rd(6'd32, d); chk("R1 mask width", d, 32'h0000_00FF);
        wr(6'd31, 32'hA5C3_1E7B); rd(6'd31, d); chk("R1 lane readback", d, 32'hA5C3_1E7B);
        rd(6'd20, d); chk("R1 unused address", d, 0);
        wr(6'd30, 0); wr(6'd31, 0); wr(6'd32, 0); wr(6'd33, 32'hFF);

        // Sweep: every group, every code
        for (int g = 0; g < 8; g++) begin
            for (int code = 0; code < 8; code++) begin
                int lane, pin;
                lane = (g * 5 + code + 3) % 16;
                pin  = lane * 8 + g;
                pins = '0;
                idle(4);
                wr(6'd30, 32'(code) << (3 * g));
                wr(6'd31, 32'(lane) << (4 * g));
                wr(6'd32, 32'h1 << g);
                wr(6'd33, 32'hFF);
                idle(4);
                check_group(g, code, 0);
                setpin(pin, 1); idle(4);
                check_group(g, code, 1);
                setpin(pin, 0); idle(4);
                check_group(g, code, 2);
                wr(6'd33, 32'h1 << g); idle(3);
                check_group(g, code, 3);
            end
        end

        // R7 routing: group 2, lane 5, both edges
        pins = '0;
        wr(6'd30, 32'd7 << 6); wr(6'd31, 32'd5 << 8); wr(6'd32, 32'h4); idle(4);
        wr(6'd33, 32'hFF); idle(2);
        setpin(6 * 8 + 2, 1); setpin(5 * 8 + 3, 1); idle(4);
        rd(6'd34, d); chk("R7 neighbour pins ignored", d, 0);
        chk("R7 irq quiet", 32'(irq), 0);
        setpin(5 * 8 + 2, 1); idle(4);
        rd(6'd34, d); chk("R7 routed pin sets group 2", d, 32'h4);

        // R6 ack with zero bits leaves it; R10 status writes ignored
        wr(6'd33, 32'hFB); idle(2);
        rd(6'd34, d); chk("R6 zero-bit ack ignored", d, 32'h4);
        wr(6'd34, 0); wr(6'd35, 0); idle(2);
        rd(6'd34, d); chk("R10 raw write ignored", d, 32'h4);
        rd(6'd30, d); chk("R10 config untouched", d, 32'd7 << 6);

        // R4 mask off keeps irq low with raw set
        wr(6'd32, 0); idle(3);
        rd(6'd35, d); chk("R4 masked clear when mask off", d, 0);
        chk("R4 irq low when mask off", 32'(irq), 0);
        rd(6'd34, d); chk("R4 raw kept when mask off", d, 32'h4);

        // R9 exact latency: group 0, lane 0, rising edge
        pins = '0;
        wr(6'd30, 32'd5); wr(6'd31, 0); wr(6'd32, 32'h1); idle(4);
        wr(6'd33, 32'hFF); idle(2);
        chk("R9 irq idle before edge", 32'(irq), 0);
        @(negedge clk); pins[0] = 1;
        @(negedge clk); chk("R9 edge1 quiet", 32'(irq), 0);
        @(negedge clk); chk("R9 edge2 quiet", 32'(irq), 0);
        @(negedge clk); chk("R9 edge3 quiet", 32'(irq), 0);
        @(negedge clk); chk("R9 irq at edge4", 32'(irq), 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule